// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This block is a purely combinational shifter for one N-bit register operand (32 bits by default). A 3-bit operation code selects one of eight moves: logical left or right, arithmetic left or right, rotation left or right within the word, and rotation left or right through the carry flag. A shift count from 0 to N is applied in a single pass, and the block returns the moved word, the new carry flag and an overflow flag that only the arithmetic left shift raises.

The carry flag always ends up holding the last bit that left the word, or for plain rotations the last bit that wrapped around. For the two through-carry rotations, the carry flag and the word form one ring of N+1 bits. The block holds no state: the caller registers the result and the flags. Every pin is a plain control or data pin with no handshake, because a value presented at the inputs is answered in the same cycle and there is nothing to stall.

Top module: `shift_rot_unit`

## Requirements
- R1: The operation code is 0 logical left, 1 logical right, 2 arithmetic right, 3 arithmetic left, 4 rotate left, 5 rotate right, 6 rotate left through carry, 7 rotate right through carry; any count above N acts exactly as a count of N.
- R2: A count of 0 returns the operand unchanged, passes the carry input to the carry output and keeps overflow low, for every operation code.
- R3: Logical left shift by k fills the low k bits with 0 and sets the carry output to operand bit N-k.
- R4: Logical right shift by k fills the high k bits with 0 and sets the carry output to operand bit k-1.
- R5: Arithmetic right shift by k copies the operand's sign bit into the high k bits and sets the carry output to operand bit k-1.
- R6: Arithmetic left shift gives the same word and carry as logical left shift, and raises overflow when any most-significant bit seen during the k one-bit steps differs from the original sign bit (the zero fill counts as such a bit when k equals N).
- R7: Rotate left by k moves the top k bits into the bottom, and the carry output equals bit 0 of the result.
- R8: Rotate right by k moves the bottom k bits into the top, and the carry output equals bit N-1 of the result.
- R9: Rotate left through carry turns the ring {carry, word} of N+1 bits left by k: the old carry enters bit k-1 and operand bit N-k becomes the new carry.
- R10: Rotate right through carry turns the same ring right by k: the old carry enters bit N-k and operand bit k-1 becomes the new carry.
- R11: Overflow is low for every operation code other than 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opd_a | input | N | Operand word |
| op_sel | input | 3 | Operation code (see R1) |
| sh_cnt | input | CW | Shift count; values above N act as N |
| c_in | input | 1 | Carry flag before the operation |
| res_o | output | N | Moved word |
| c_out | output | 1 | Carry flag after the operation |
| ovf_o | output | 1 | Sign change during an arithmetic left shift |

## Verification
An 8-bit build is driven with every operand value, every operation code, both carry values and every count a 4-bit count field can hold. The counts from 1 to N separate the fill rules (zero, sign copy, wrap, carry entry) and the position of the bit that lands in the carry. Counts above N show whether saturation is applied before the move or wraps the count. The operands with the top bits equal and those with them mixed tell apart whether overflow tracks every step or only the final sign, and the two carry values show whether the carry enters the ring only in the through-carry rotations.

// File: rtl/shr_pkg.sv
package shr_pkg;
  typedef enum logic [2:0] {
    OP_LSL = 3'd0,
    OP_LSR = 3'd1,
    OP_ASR = 3'd2,
    OP_ASL = 3'd3,
    OP_ROL = 3'd4,
    OP_ROR = 3'd5,
    OP_RCL = 3'd6,
    OP_RCR = 3'd7
  } shr_op_e;

  function automatic logic is_rightward(input shr_op_e op);
    return (op == OP_LSR) || (op == OP_ASR) || (op == OP_ROR) || (op == OP_RCR);
  endfunction
endpackage

// File: rtl/shr_cnt_sat.sv
module shr_cnt_sat #(
  parameter int N  = 32,
  parameter int CW = 8,
  parameter int AW = $clog2(N + 1)
) (
  input  logic [CW-1:0] cnt_i,
  output logic [AW-1:0] amt_o
);
  localparam logic [CW-1:0] LIMIT = CW'(N);

  always_comb begin
    if (cnt_i > LIMIT) amt_o = AW'(N);
    else               amt_o = cnt_i[AW-1:0];
  end
endmodule

// File: rtl/shr_funnel.sv
module shr_funnel #(
  parameter int W  = 33,
  parameter int AW = 6
) (
  input  logic [2*W-1:0] din,
  input  logic [AW-1:0]  amt,
  output logic [W-1:0]   dout
);
  logic [2*W-1:0] stage [AW+1];

  assign stage[0] = din;

  for (genvar s = 0; s < AW; s++) begin : g_stage
    assign stage[s+1] = amt[s] ? (stage[s] << (1 << s)) : stage[s];
  end

  assign dout = stage[AW][2*W-1:W];
endmodule

// File: rtl/shr_asl_ovf.sv
module shr_asl_ovf #(
  parameter int N  = 32,
  parameter int AW = $clog2(N + 1)
) (
  input  logic [N-1:0]  a,
  input  logic [AW-1:0] amt,
  output logic          ovf
);
  logic [N:0]   ext;
  logic [N-1:0] hit;

  assign ext = {a, 1'b0};

  for (genvar i = 1; i <= N; i++) begin : g_step
    assign hit[i-1] = (32'(amt) >= i) && (ext[N-i] != a[N-1]);
  end

  assign ovf = |hit;
endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit
  import shr_pkg::*;
#(
  parameter int N  = 32,
  parameter int CW = 8
) (
  input  logic [N-1:0]  opd_a,
  input  logic [2:0]    op_sel,
  input  logic [CW-1:0] sh_cnt,
  input  logic          c_in,
  output logic [N-1:0]  res_o,
  output logic          c_out,
  output logic          ovf_o
);
  localparam int W  = N + 1;
  localparam int AW = $clog2(N + 1);

  shr_op_e       op;
  logic [AW-1:0] amt;
  logic [N-1:0]  a_rev;
  logic [W-1:0]  upper, lower;
  logic [W-1:0]  fout;
  logic [N-1:0]  f_rev;
  logic          ovf_raw;
  logic          rightward;

  assign op        = shr_op_e'(op_sel);
  assign rightward = is_rightward(op);

  for (genvar i = 0; i < N; i++) begin : g_rev
    assign a_rev[i] = opd_a[N-1-i];
    assign f_rev[i] = fout[N-1-i];
  end

  shr_cnt_sat #(.N(N), .CW(CW), .AW(AW)) u_sat (
    .cnt_i (sh_cnt),
    .amt_o (amt)
  );

  // Right moves run on the bit-reversed word through the same left funnel.
  always_comb begin
    upper = {c_in, opd_a};
    lower = '0;
    unique case (op)
      OP_LSL, OP_ASL: begin upper = {c_in, opd_a}; lower = '0; end
      OP_LSR:         begin upper = {c_in, a_rev}; lower = '0; end
      OP_ASR:         begin upper = {c_in, a_rev}; lower = {W{opd_a[N-1]}}; end
      OP_ROL:         begin upper = {c_in, opd_a}; lower = {opd_a, 1'b0}; end
      OP_ROR:         begin upper = {c_in, a_rev}; lower = {a_rev, 1'b0}; end
      OP_RCL:         begin upper = {c_in, opd_a}; lower = {c_in, opd_a}; end
      OP_RCR:         begin upper = {c_in, a_rev}; lower = {c_in, a_rev}; end
      default:        begin upper = {c_in, opd_a}; lower = '0; end
    endcase
  end

  shr_funnel #(.W(W), .AW(AW)) u_funnel (
    .din  ({upper, lower}),
    .amt  (amt),
    .dout (fout)
  );

  shr_asl_ovf #(.N(N), .AW(AW)) u_ovf (
    .a   (opd_a),
    .amt (amt),
    .ovf (ovf_raw)
  );

  assign res_o = rightward ? f_rev : fout[N-1:0];
  assign c_out = fout[N];
  assign ovf_o = (op == OP_ASL) && ovf_raw;
endmodule

// File: rtl/shift_rot_unit_chk.sv
module shift_rot_unit_chk #(
  parameter int N  = 32,
  parameter int CW = 8
) (
  input logic [N-1:0]  opd_a,
  input logic [2:0]    op_sel,
  input logic [CW-1:0] sh_cnt,
  input logic          c_in,
  input logic [N-1:0]  res_o,
  input logic          c_out,
  input logic          ovf_o
);
  localparam logic [CW-1:0] LIM = CW'(N);

  always_comb begin
    if (sh_cnt == '0)
      assert_zero_count_R2: assert (res_o == opd_a && c_out == c_in && !ovf_o)
        else $error("zero count altered state");
    if (op_sel != 3'd3)
      assert_no_overflow_R11: assert (!ovf_o)
        else $error("overflow outside arithmetic left");
    if (op_sel == 3'd0 && sh_cnt >= LIM)
      assert_full_lsl_clear_R3: assert (res_o == '0 && c_out == opd_a[0])
        else $error("full left shift not cleared");
    if ((op_sel == 3'd4 || op_sel == 3'd5) && sh_cnt >= LIM)
      assert_full_rotate_R1: assert (res_o == opd_a)
        else $error("full rotation changed word");
    if (op_sel == 3'd2)
      assert_asr_sign_R5: assert (res_o[N-1] == opd_a[N-1])
        else $error("sign lost in arithmetic right");
    if (op_sel == 3'd7 && sh_cnt == CW'(1))
      assert_rcr_one_R10: assert (res_o[N-1] == c_in && c_out == opd_a[0])
        else $error("carry ring right broken");
  end
endmodule

bind shift_rot_unit shift_rot_unit_chk #(.N(N), .CW(CW)) u_chk (
  .opd_a  (opd_a),
  .op_sel (op_sel),
  .sh_cnt (sh_cnt),
  .c_in   (c_in),
  .res_o  (res_o),
  .c_out  (c_out),
  .ovf_o  (ovf_o)
);

// File: tb/tb_shift_rot_unit.sv
`timescale 1ns/1ps
module tb_shift_rot_unit;
  localparam int TN  = 8;
  localparam int TCW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [TN-1:0]  opd_a;
  logic [2:0]     op_sel;
  logic [TCW-1:0] sh_cnt;
  logic           c_in;
  logic [TN-1:0]  res_o;
  logic           c_out;
  logic           ovf_o;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  shift_rot_unit #(.N(TN), .CW(TCW)) dut (
    .opd_a  (opd_a),
    .op_sel (op_sel),
    .sh_cnt (sh_cnt),
    .c_in   (c_in),
    .res_o  (res_o),
    .c_out  (c_out),
    .ovf_o  (ovf_o)
  );

  // Bit-at-a-time model: returns {ovf, carry, word}.
  function automatic logic [TN+1:0] model(input int op, input logic [TN-1:0] a,
                                          input int cnt, input logic cin);
    logic [TN-1:0] r = a;
    logic c = cin;
    logic nc;
    logic ov = 1'b0;
    int k = (cnt > TN) ? TN : cnt;
    for (int j = 0; j < k; j++) begin
      case (op)
        0, 3: begin
          c = r[TN-1]; r = {r[TN-2:0], 1'b0};
          if (op == 3 && r[TN-1] != a[TN-1]) ov = 1'b1;
        end
        1: begin c = r[0]; r = {1'b0, r[TN-1:1]}; end
        2: begin c = r[0]; r = {r[TN-1], r[TN-1:1]}; end
        4: begin r = {r[TN-2:0], r[TN-1]}; c = r[0]; end
        5: begin r = {r[0], r[TN-1:1]}; c = r[TN-1]; end
        6: begin nc = r[TN-1]; r = {r[TN-2:0], c}; c = nc; end
        default: begin nc = r[0]; r = {c, r[TN-1:1]}; c = nc; end
      endcase
    end
    return {ov, c, r};
  endfunction

  function automatic string tag_of(input int op, input int cnt);
    if (cnt == 0)  return "R2";
    if (cnt > TN)  return "R1";
    case (op)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      6: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(input int op, input int a, input int cnt, input bit cin);
    logic [TN+1:0] exp;
    string tag;
    @(posedge clk);
    #1;
    op_sel = 3'(op); opd_a = TN'(a); sh_cnt = TCW'(cnt); c_in = cin;
    @(negedge clk);
    exp = model(op, TN'(a), cnt, cin);
    tag = tag_of(op, cnt);
    vectors++;
    if (res_o !== exp[TN-1:0] || c_out !== exp[TN]) begin
      fails++;
      $display("FAIL %s op=%0d a=%h cnt=%0d cin=%0b: got word=%h c=%0b expected word=%h c=%0b",
               tag, op, a, cnt, cin, res_o, c_out, exp[TN-1:0], exp[TN]);
    end
    if (ovf_o !== exp[TN+1]) begin
      fails++;
      $display("FAIL %s op=%0d a=%h cnt=%0d ovf: got %0b expected %0b",
               (op == 3) ? "R6" : "R11", op, a, cnt, ovf_o, exp[TN+1]);
    end
  endtask

  initial begin
    opd_a = '0; op_sel = '0; sh_cnt = '0; c_in = 1'b0;
    // R2: initial idle inputs give an all-zero answer
    apply(0, 0, 0, 1'b0);
    // Sweep covering R1 and R3 through R11
    for (int op = 0; op < 8; op++)
      for (int cnt = 0; cnt < (1 << TCW); cnt++)
        for (int cin = 0; cin < 2; cin++)
          for (int a = 0; a < (1 << TN); a++)
            apply(op, a, cnt, cin[0]);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, got %0d vectors expected 65537", vectors);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule